// File: doc/BRIEF.md
# Dual Half-Bridge Protection Sequencer

This block supervises a two-leg power stage. Each leg takes an enable and a level command and is decoded into a high-side and a low-side gate request. The block sits between those commands and the gate drivers. It withholds or forwards the commands according to an active-low sleep input and a set of comparator flags that are already synchronised to the system clock. The flags are supply undervoltage, charge-pump undervoltage, overcurrent, sense-resistor trip, thermal warning and thermal shutdown.

The protection responses differ by fault. Supply undervoltage and thermal shutdown turn off every switch and the charge pump. Supply undervoltage does this without a fault indication, and thermal shutdown does it with one. Charge-pump undervoltage and the thermal warning only pull the fault line low. An overcurrent or a sense trip is first deglitched. Once confirmed, it forces every switch off for a fixed retry interval, then tries again, and keeps repeating while the short remains.

Every delay is a clock-cycle counter set by a parameter: the deglitch window, the retry interval, the wake-up settle time and the dead time between sides. All outputs are registered.

Top module: `hb_guard_top`

## Requirements
- R1: During and right after reset, with sleep low, all gate outputs are 0, the charge-pump enable is 0, and the fault output is 1 (released).
- R2: Per leg, enable=0 gives both gates 0, enable=1 with level=0 gives low-side=1, and enable=1 with level=1 gives high-side=1. The gate outputs update one clock edge after the command when no dead time is pending.
- R3: When a conducting gate must turn off, both gates of that leg stay 0 for DEAD_CYC+1 edges. The newly requested side turns on at the DEAD_CYC+2nd edge after the command change.
- R4: The high-side and low-side outputs of a leg are never 1 together.
- R5: The trip input (overcurrent OR sense trip) must be sampled high on DEG_CYC consecutive edges before it is confirmed. A shorter pulse changes nothing. One edge after confirmation, all gates of both legs are 0 and the fault output is 0.
- R6: RETRY_CYC edges after confirmation, the outputs follow the commands again and the fault output returns to 1. If the trip is still present, the deglitch and retry cycle repeats.
- R7: Charge-pump undervoltage drives the fault output to 0 one edge later and leaves the gates unaffected. The fault is released one edge after the flag clears.
- R8: The thermal warning drives the fault output to 0 and leaves the gates and the charge pump unaffected.
- R9: Supply undervoltage turns off all gates and the charge pump one edge later and does not assert the fault output. Operation resumes after the flag clears.
- R10: Thermal shutdown turns off all gates and the charge pump and asserts the fault output one edge later. Recovery is automatic once the flag clears.
- R11: With sleep low, the gates and the charge pump are 0, the fault output is 1, and the overcurrent state is cleared. After sleep rises, the charge pump turns on at the first edge. Gate commands are ignored for WAKE_CYC edges and take effect at edge WAKE_CYC+1.
- R12: Disable sources have the priority sleep, then supply undervoltage, then thermal shutdown, then the overcurrent retry, then normal decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_n_i | input | 1 | Active-low sleep request |
| en_i | input | N_LEGS | Per-leg enable |
| lvl_i | input | N_LEGS | Per-leg level (1 = high side) |
| uv_i | input | 1 | Supply undervoltage flag |
| cpuv_i | input | 1 | Charge-pump undervoltage flag |
| oc_i | input | 1 | Switch overcurrent flag |
| strip_i | input | 1 | Sense-resistor trip flag |
| otw_i | input | 1 | Thermal warning flag |
| ots_i | input | 1 | Thermal shutdown flag |
| hs_o | output | N_LEGS | High-side gate requests |
| ls_o | output | N_LEGS | Low-side gate requests |
| cp_en_o | output | 1 | Charge-pump enable |
| fault_n_o | output | 1 | Active-low fault indication |

## Verification
The assertions assume that every flag and command is already synchronous to the clock and holds for at least one full cycle. They also assume DEAD_CYC is at least 1, because the side-to-side checks depend on a gap of one or more cycles. The random phase drives only the level flags and leg commands, keeps the trip inputs low and holds each vector for longer than the dead time. As a result, each sample is a steady state that a simple function can predict. The trip, retry and wake sequences are covered by directed cases timed to the exact edge.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  typedef enum logic {
    OC_RUN  = 1'b0,
    OC_HOLD = 1'b1
  } oc_state_e;

  function automatic int cyc_per_us(input int clk_hz);
    return clk_hz / 1_000_000;
  endfunction
endpackage

// File: rtl/hbg_wake.sv
module hbg_wake #(
  parameter int WAKE_CYC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_n_i,
  output logic ready_o
);
  localparam int W = $clog2(WAKE_CYC + 1);
  localparam logic [W-1:0] LIM = W'(WAKE_CYC);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !sleep_n_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LIM) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready_o = (cnt_q == LIM);

  p_wake_sleep_r11: assert property (@(posedge clk) disable iff (rst)
    !sleep_n_i |=> !ready_o);
endmodule

// File: rtl/hbg_oc_timer.sv
module hbg_oc_timer
  import hbg_pkg::*;
#(
  parameter int DEG_CYC   = 150,
  parameter int RETRY_CYC = 80000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic trip_i,
  output logic block_o
);
  localparam int DW = $clog2(DEG_CYC + 1);
  localparam int RW = $clog2(RETRY_CYC + 1);
  localparam logic [DW-1:0] DLIM = DW'(DEG_CYC - 1);
  localparam logic [RW-1:0] RLIM = RW'(RETRY_CYC - 1);

  oc_state_e    st_q;
  logic [DW-1:0] dcnt_q;
  logic [RW-1:0] rcnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      st_q   <= OC_RUN;
      dcnt_q <= '0;
      rcnt_q <= '0;
    end else begin
      case (st_q)
        OC_RUN: begin
          if (!trip_i) begin
            dcnt_q <= '0;
          end else if (dcnt_q == DLIM) begin
            st_q   <= OC_HOLD;
            dcnt_q <= '0;
            rcnt_q <= '0;
          end else begin
            dcnt_q <= dcnt_q + 1'b1;
          end
        end
        default: begin
          if (rcnt_q == RLIM) begin
            st_q   <= OC_RUN;
            rcnt_q <= '0;
          end else begin
            rcnt_q <= rcnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign block_o = (st_q == OC_HOLD);

  p_trip_seen_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(block_o) |-> $past(trip_i));
  p_retry_bound_r6: assert property (@(posedge clk) disable iff (rst)
    block_o |-> (rcnt_q <= RLIM));
  p_sleep_clear_r11: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !block_o);
endmodule

// File: rtl/hbg_leg.sv
module hbg_leg #(
  parameter int DEAD_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic allow_i,
  input  logic en_i,
  input  logic lvl_i,
  output logic hs_o,
  output logic ls_o
);
  localparam int W = $clog2(DEAD_CYC + 1);
  localparam logic [W-1:0] DLOAD = W'(DEAD_CYC);

  logic want_hs, want_ls;
  logic hs_q, ls_q;
  logic [W-1:0] gap_q;

  always_comb begin
    want_hs = allow_i & en_i & lvl_i;
    want_ls = allow_i & en_i & ~lvl_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q  <= 1'b0;
      ls_q  <= 1'b0;
      gap_q <= '0;
    end else if ((hs_q && !want_hs) || (ls_q && !want_ls)) begin
      hs_q  <= 1'b0;
      ls_q  <= 1'b0;
      gap_q <= DLOAD;
    end else if (gap_q != '0) begin
      gap_q <= gap_q - 1'b1;
    end else begin
      hs_q <= want_hs;
      ls_q <= want_ls;
    end
  end

  assign hs_o = hs_q;
  assign ls_o = ls_q;

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (rst)
    !(hs_q && ls_q));
  p_gap_after_ls_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(ls_q) |=> !hs_q);
  p_gap_after_hs_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(hs_q) |=> !ls_q);
endmodule

// File: rtl/hb_guard_top.sv
module hb_guard_top
  import hbg_pkg::*;
#(
  parameter int N_LEGS    = 2,
  parameter int CLK_HZ    = 50_000_000,
  parameter int DEG_CYC   = 3 * cyc_per_us(CLK_HZ),
  parameter int RETRY_CYC = 1600 * cyc_per_us(CLK_HZ),
  parameter int WAKE_CYC  = 1000 * cyc_per_us(CLK_HZ),
  parameter int DEAD_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_n_i,
  input  logic [N_LEGS-1:0] en_i,
  input  logic [N_LEGS-1:0] lvl_i,
  input  logic              uv_i,
  input  logic              cpuv_i,
  input  logic              oc_i,
  input  logic              strip_i,
  input  logic              otw_i,
  input  logic              ots_i,
  output logic [N_LEGS-1:0] hs_o,
  output logic [N_LEGS-1:0] ls_o,
  output logic              cp_en_o,
  output logic              fault_n_o
);
  logic awake;
  logic oc_block;
  logic allow;
  logic cp_en_q;
  logic fault_n_q;

  hbg_wake #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk(clk), .rst(rst), .sleep_n_i(sleep_n_i), .ready_o(awake)
  );

  hbg_oc_timer #(.DEG_CYC(DEG_CYC), .RETRY_CYC(RETRY_CYC)) u_oc (
    .clk(clk), .rst(rst), .clr_i(!sleep_n_i),
    .trip_i(oc_i | strip_i), .block_o(oc_block)
  );

  // priority chain R12: sleep > supply UV > thermal shutdown > OC retry > decode
  always_comb begin
    if (!sleep_n_i || !awake) allow = 1'b0;
    else if (uv_i)            allow = 1'b0;
    else if (ots_i)           allow = 1'b0;
    else if (oc_block)        allow = 1'b0;
    else                      allow = 1'b1;
  end

  for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
    hbg_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk(clk), .rst(rst), .allow_i(allow),
      .en_i(en_i[g]), .lvl_i(lvl_i[g]),
      .hs_o(hs_o[g]), .ls_o(ls_o[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cp_en_q   <= 1'b0;
      fault_n_q <= 1'b1;
    end else begin
      cp_en_q   <= sleep_n_i & ~uv_i & ~ots_i;
      fault_n_q <= ~(sleep_n_i & (oc_block | cpuv_i | otw_i | ots_i));
    end
  end

  assign cp_en_o   = cp_en_q;
  assign fault_n_o = fault_n_q;

  p_uv_off_r9: assert property (@(posedge clk) disable iff (rst)
    uv_i |=> (hs_o == '0 && ls_o == '0 && !cp_en_o));
  p_ots_off_r10: assert property (@(posedge clk) disable iff (rst)
    ots_i |=> (hs_o == '0 && ls_o == '0 && !cp_en_o));
  p_sleep_r11: assert property (@(posedge clk) disable iff (rst)
    !sleep_n_i |=> (hs_o == '0 && ls_o == '0 && !cp_en_o && fault_n_o));
  p_cpuv_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (cpuv_i && sleep_n_i) |=> !fault_n_o);
  p_oc_gates_r5: assert property (@(posedge clk) disable iff (rst)
    oc_block |=> (hs_o == '0 && ls_o == '0));
endmodule

// File: tb/hb_guard_top_bench.sv
module hb_guard_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 2;
  localparam int DEG = 4;
  localparam int RTY = 24;
  localparam int WK  = 12;
  localparam int DT  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_n = 1'b0;
  logic [N-1:0] en = '0, lvl = '0;
  logic uv = 0, cpuv = 0, oc = 0, strip = 0, otw = 0, ots = 0;
  logic [N-1:0] hs, ls;
  logic cp_en, fault_n;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hb_guard_top #(
    .N_LEGS(N), .DEG_CYC(DEG), .RETRY_CYC(RTY), .WAKE_CYC(WK), .DEAD_CYC(DT)
  ) u_hb_guard_top (
    .clk(clk), .rst(rst), .sleep_n_i(sleep_n), .en_i(en), .lvl_i(lvl),
    .uv_i(uv), .cpuv_i(cpuv), .oc_i(oc), .strip_i(strip), .otw_i(otw),
    .ots_i(ots), .hs_o(hs), .ls_o(ls), .cp_en_o(cp_en), .fault_n_o(fault_n)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_hs(input logic [N-1:0] e, input logic [N-1:0] l,
                                          input logic u, input logic t);
    return (u || t) ? '0 : (e & l);
  endfunction

  function automatic logic [N-1:0] exp_ls(input logic [N-1:0] e, input logic [N-1:0] l,
                                          input logic u, input logic t);
    return (u || t) ? '0 : (e & ~l);
  endfunction

  function automatic logic exp_fault_n(input logic c, input logic w, input logic t);
    return !(c || w || t);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    tick(3);
    cpuv = 1;
    rst = 0;
    tick(2);
    // R1 / R11: reset and sleep state, fault released although cpuv is high
    chk("R1 hs", 8'(hs), 8'h0);
    chk("R1 ls", 8'(ls), 8'h0);
    chk("R1 cp_en", 8'(cp_en), 8'h0);
    chk("R11 fault released in sleep", 8'(fault_n), 8'h1);
    cpuv = 0;

    // R11 wake delay
    en = 2'b01; lvl = 2'b01; sleep_n = 1;
    tick(1);
    chk("R11 cp on at first edge", 8'(cp_en), 8'h1);
    tick(WK - 1);
    chk("R11 commands ignored during wake", 8'(hs), 8'h0);
    tick(1);
    chk("R11 commands follow after wake", 8'(hs), 8'h1);

    // R3 dead time high -> low
    lvl[0] = 0;
    tick(1);
    chk("R3 both off first edge", 8'({hs[0], ls[0]}), 8'h0);
    tick(DT);
    chk("R3 still off", 8'({hs[0], ls[0]}), 8'h0);
    tick(1);
    chk("R3 low side on", 8'({hs[0], ls[0]}), 8'h1);
    lvl[0] = 1;
    tick(DT + 2);
    chk("R3 high side back", 8'({hs[0], ls[0]}), 8'h2);

    // R2 decode on leg 1
    en[1] = 1; lvl[1] = 0;
    tick(1);
    chk("R2 leg1 low side", 8'({hs[1], ls[1]}), 8'h1);
    en[1] = 0;
    tick(1);
    chk("R2 leg1 high impedance", 8'({hs[1], ls[1]}), 8'h0);
    en[1] = 1;
    tick(DT + 2);
    chk("R2 leg1 low side again", 8'({hs[1], ls[1]}), 8'h1);

    // R5 short sense-trip pulse is ignored
    strip = 1;
    tick(DEG - 1);
    strip = 0;
    tick(3);
    chk("R5 glitch hs kept", 8'(hs), 8'h1);
    chk("R5 glitch fault kept high", 8'(fault_n), 8'h1);

    // R5 / R6 persistent overcurrent
    oc = 1;
    tick(DEG);
    chk("R5 before confirm", 8'({hs, ls}), 8'b0110);
    tick(1);
    chk("R5 all gates off", 8'({hs, ls}), 8'h0);
    chk("R5 fault low", 8'(fault_n), 8'h0);
    tick(RTY - 1);
    chk("R6 still held", 8'({hs, ls}), 8'h0);
    tick(1);
    chk("R6 retry follows commands", 8'({hs, ls}), 8'b0110);
    chk("R6 fault released on retry", 8'(fault_n), 8'h1);
    tick(DEG - 1);
    chk("R6 retry before re-trip", 8'(hs), 8'h1);
    tick(1);
    chk("R6 re-trip gates off", 8'({hs, ls}), 8'h0);
    chk("R6 re-trip fault low", 8'(fault_n), 8'h0);

    // R11 / R12 sleep overrides and clears the retry
    sleep_n = 0; oc = 0;
    tick(2);
    chk("R12 sleep fault released", 8'(fault_n), 8'h1);
    chk("R11 sleep cp off", 8'(cp_en), 8'h0);
    sleep_n = 1;
    tick(WK);
    chk("R11 wake hold", 8'(hs), 8'h0);
    tick(1);
    chk("R11 retry cleared by sleep", 8'({hs, ls}), 8'b0110);
    chk("R11 fault after wake", 8'(fault_n), 8'h1);

    // R7 charge-pump undervoltage
    cpuv = 1;
    tick(1);
    chk("R7 fault low", 8'(fault_n), 8'h0);
    chk("R7 gates unaffected", 8'({hs, ls}), 8'b0110);
    cpuv = 0;
    tick(1);
    chk("R7 fault released", 8'(fault_n), 8'h1);

    // R8 thermal warning
    otw = 1;
    tick(1);
    chk("R8 fault low", 8'(fault_n), 8'h0);
    chk("R8 gates and cp unaffected", 8'({cp_en, hs, ls}), 8'b10110);
    otw = 0;
    tick(1);

    // R9 supply undervoltage is silent
    uv = 1; otw = 1;
    tick(1);
    chk("R9 gates off", 8'({hs, ls}), 8'h0);
    chk("R9 cp off", 8'(cp_en), 8'h0);
    otw = 0;
    tick(1);
    chk("R9 no fault indication", 8'(fault_n), 8'h1);
    uv = 0;
    tick(DT + 2);
    chk("R9 resume", 8'({cp_en, hs, ls}), 8'b10110);

    // R10 / R12 thermal shutdown with overcurrent held low
    ots = 1;
    tick(1);
    chk("R10 gates off", 8'({hs, ls}), 8'h0);
    chk("R10 cp off fault low", 8'({cp_en, fault_n}), 8'h0);
    tick(3);
    ots = 0;
    tick(1);
    chk("R10 resume", 8'({cp_en, fault_n, hs, ls}), 8'b110110);

    // random steady-state phase (R2, R7, R8, R9, R10, R12)
    for (int i = 0; i < 150; i++) begin
      en   = N'($urandom);
      lvl  = N'($urandom);
      uv   = ($urandom % 6) == 0;
      ots  = ($urandom % 6) == 0;
      cpuv = ($urandom % 5) == 0;
      otw  = ($urandom % 5) == 0;
      tick(DT + 6);
      chk("R2 rand hs", 8'(hs), 8'(exp_hs(en, lvl, uv, ots)));
      chk("R2 rand ls", 8'(ls), 8'(exp_ls(en, lvl, uv, ots)));
      chk("R9 rand cp", 8'(cp_en), 8'(!(uv || ots)));
      chk("R7 rand fault", 8'(fault_n), 8'(exp_fault_n(cpuv, otw, ots)));
    end

    finish_run();
  end
endmodule